// File: doc/BRIEF.md
# Merging Write Buffer

This block holds pending write ranges for a memory controller. Each incoming write, given as a byte address and a byte length, is compared against every entry already held. When the new range overlaps an entry, or touches it with no gap on either side, the write is folded into that entry. The entry then covers the union of the two ranges, so the scheduler issues one burst where it would otherwise issue two. A fold is refused when the union would exceed one DRAM burst; the write then takes a fresh slot.

Read lookups are checked against the held ranges. A read whose whole range sits inside one entry reports a hit, so the controller can serve it from the buffer rather than from DRAM. The oldest entry is offered to the DRAM scheduler through a pop port. The number of occupied slots is exported for the read/write mode controller. Only writes that are actually taken are counted in a statistics counter. Payload data and DRAM timing are handled elsewhere.

Top module: `merging_wbuf`

## Requirements
- R1: A write whose range [addr, addr+len) overlaps a held entry is accepted and merges into it. The entry becomes the union of the two ranges, and occupancy does not change.
- R2: A write that ends exactly at an entry's start, or starts exactly at an entry's end, merges in the same way. A gap of even one byte gives a new entry.
- R3: A merge is made only when the union spans at most BURST_BYTES (64) bytes. Otherwise the write is stored as a new entry. Every held entry has a length from 1 to BURST_BYTES.
- R4: When all DEPTH (4) slots are occupied and the write cannot merge, wr_ready is 0 in that cycle and the buffer is left unchanged. A write that can merge is still accepted when the buffer is full.
- R5: rd_hit is 1 in the cycle after rd_valid is sampled if and only if [rd_addr, rd_addr+rd_len) lies wholly within a single held entry. At all other times rd_hit is 0.
- R6: Entries leave through the pop port in the order their slots were first allocated. pop_valid is 1 whenever occupancy is non-zero, and pop_addr and pop_len show the oldest entry. A pop takes place on a cycle with pop_valid and pop_ready both 1.
- R7: occupancy gives the number of held entries. Each pop lowers it by one and each new allocation raises it by one, and it never exceeds DEPTH.
- R8: accept_cnt increases by one for each cycle with wr_valid and wr_ready both 1, and for no other cycle.
- R9: When several entries could take a write, the lowest slot (the oldest) is chosen. In a cycle where the oldest entry is popped, that entry is not a merge target.
- R10: After reset the buffer is empty: occupancy 0, pop_valid 0, rd_hit 0, accept_cnt 0 and wr_ready 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write taken this cycle |
| wr_addr | input | ADDR_W | Write start byte address |
| wr_len | input | LEN_W | Write length in bytes, 1 to BURST_BYTES |
| rd_valid | input | 1 | Read lookup present |
| rd_addr | input | ADDR_W | Read start byte address |
| rd_len | input | LEN_W | Read length in bytes |
| rd_hit | output | 1 | Read covered by one held entry (registered) |
| pop_valid | output | 1 | An entry is available |
| pop_ready | input | 1 | Scheduler takes the oldest entry |
| pop_addr | output | ADDR_W | Start address of the oldest entry |
| pop_len | output | LEN_W | Length of the oldest entry |
| occupancy | output | CNT_W | Number of held entries |
| accept_cnt | output | STAT_W | Count of accepted writes |

## Verification
wr_ready, pop_valid, pop_addr and pop_len are combinational from the present state and the inputs. The bench drives a stimulus on the falling edge and samples these outputs one nanosecond later, before the rising edge that acts on them. occupancy, accept_cnt and rd_hit change on the rising edge that samples the stimulus. They are read just after the next falling edge, which is one cycle after the stimulus. A stalled write is held for a single cycle only, and the occupancy and counter values read afterwards show whether it was taken.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

  typedef enum logic [1:0] {
    WA_NONE  = 2'd0,
    WA_MERGE = 2'd1,
    WA_ALLOC = 2'd2,
    WA_STALL = 2'd3
  } wr_act_e;

endpackage

// File: rtl/mwb_match.sv
module mwb_match #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 7,
  parameter int BURST  = 64
) (
  input  logic              e_valid,
  input  logic [ADDR_W-1:0] e_base,
  input  logic [LEN_W-1:0]  e_len,
  input  logic [ADDR_W-1:0] w_base,
  input  logic [LEN_W-1:0]  w_len,
  input  logic [ADDR_W-1:0] r_base,
  input  logic [LEN_W-1:0]  r_len,
  output logic              can_join,
  output logic [ADDR_W-1:0] join_base,
  output logic [LEN_W-1:0]  join_len,
  output logic              covers
);
  localparam int EW = ADDR_W + 1;

  logic [EW-1:0] e_lo, e_hi, w_lo, w_hi, r_lo, r_hi;
  logic [EW-1:0] u_lo, u_hi, u_span;
  logic          touch;

  always_comb begin
    e_lo   = {1'b0, e_base};
    e_hi   = e_lo + EW'(e_len);
    w_lo   = {1'b0, w_base};
    w_hi   = w_lo + EW'(w_len);
    r_lo   = {1'b0, r_base};
    r_hi   = r_lo + EW'(r_len);
    // closed comparison: equal ends count as touching
    touch  = e_valid && (w_lo <= e_hi) && (e_lo <= w_hi);
    u_lo   = (w_lo < e_lo) ? w_lo : e_lo;
    u_hi   = (w_hi > e_hi) ? w_hi : e_hi;
    u_span = u_hi - u_lo;
    can_join  = touch && (u_span <= EW'(BURST));
    join_base = (w_base < e_base) ? w_base : e_base;
    join_len  = u_span[LEN_W-1:0];
    covers    = e_valid && (e_lo <= r_lo) && (r_hi <= e_hi);
  end

endmodule

// File: rtl/mwb_pick.sv
module mwb_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
    found = |req;
  end
endmodule

// File: rtl/mwb_store.sv
module mwb_store #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 7,
  parameter int DEPTH  = 4,
  parameter int BURST  = 64,
  parameter int CNT_W  = 3,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              merge_en,
  input  logic [IDX_W-1:0]  merge_idx,
  input  logic [ADDR_W-1:0] merge_base,
  input  logic [LEN_W-1:0]  merge_len,
  input  logic              alloc_en,
  input  logic [ADDR_W-1:0] alloc_base,
  input  logic [LEN_W-1:0]  alloc_len,
  input  logic              pop_en,
  output logic [ADDR_W-1:0] base_q [DEPTH],
  output logic [LEN_W-1:0]  len_q  [DEPTH],
  output logic [DEPTH-1:0]  valid,
  output logic [CNT_W-1:0]  count_q
);
  logic [ADDR_W-1:0] base_n [DEPTH];
  logic [LEN_W-1:0]  len_n  [DEPTH];
  logic [CNT_W-1:0]  cnt_mid, count_n;
  logic              upd;

  // next state: merge in place, then shift out the head, then append
  always_comb begin
    base_n  = base_q;
    len_n   = len_q;
    cnt_mid = count_q;
    if (merge_en) begin
      base_n[merge_idx] = merge_base;
      len_n[merge_idx]  = merge_len;
    end
    if (pop_en) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        base_n[i] = base_n[i+1];
        len_n[i]  = len_n[i+1];
      end
      base_n[DEPTH-1] = '0;
      len_n[DEPTH-1]  = '0;
      cnt_mid = count_q - CNT_W'(1);
    end
    count_n = cnt_mid;
    if (alloc_en) begin
      base_n[cnt_mid[IDX_W-1:0]] = alloc_base;
      len_n[cnt_mid[IDX_W-1:0]]  = alloc_len;
      count_n = cnt_mid + CNT_W'(1);
    end
    upd = merge_en | pop_en | alloc_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        base_q[i] <= '0;
        len_q[i]  <= '0;
      end
    end else if (upd) begin
      count_q <= count_n;
      base_q  <= base_n;
      len_q   <= len_n;
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) valid[i] = (CNT_W'(i) < count_q);
  end

  // R7
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  for (genvar g = 0; g < DEPTH; g++) begin : g_fit
    // R3
    burst_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid[g] |-> (len_q[g] != '0 && len_q[g] <= LEN_W'(BURST)));
  end

endmodule

// File: rtl/merging_wbuf.sv
module merging_wbuf
  import mwb_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BURST_BYTES = 64,
  parameter int DEPTH       = 4,
  parameter int STAT_W      = 16,
  localparam int LEN_W = $clog2(BURST_BYTES) + 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [LEN_W-1:0]  rd_len,
  output logic              rd_hit,
  output logic              pop_valid,
  input  logic              pop_ready,
  output logic [ADDR_W-1:0] pop_addr,
  output logic [LEN_W-1:0]  pop_len,
  output logic [CNT_W-1:0]  occupancy,
  output logic [STAT_W-1:0] accept_cnt
);
  logic [ADDR_W-1:0] ent_base [DEPTH];
  logic [LEN_W-1:0]  ent_len  [DEPTH];
  logic [DEPTH-1:0]  ent_valid;
  logic [CNT_W-1:0]  count_q;

  logic [DEPTH-1:0]  can_join, merge_ok, covers;
  logic [ADDR_W-1:0] join_base [DEPTH];
  logic [LEN_W-1:0]  join_len  [DEPTH];

  logic              can_merge, pop_fire, wr_acc;
  logic [IDX_W-1:0]  m_idx;
  wr_act_e           act;

  logic              hit_q, hit_n;
  logic [STAT_W-1:0] acc_q, acc_n;
  logic              acc_en;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    mwb_match #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST(BURST_BYTES)) u_match (
      .e_valid  (ent_valid[g]),
      .e_base   (ent_base[g]),
      .e_len    (ent_len[g]),
      .w_base   (wr_addr),
      .w_len    (wr_len),
      .r_base   (rd_addr),
      .r_len    (rd_len),
      .can_join (can_join[g]),
      .join_base(join_base[g]),
      .join_len (join_len[g]),
      .covers   (covers[g])
    );
    // the head leaving this cycle must not absorb the write
    if (g == 0) begin : g_head
      assign merge_ok[g] = can_join[g] && !pop_fire;
    end else begin : g_rest
      assign merge_ok[g] = can_join[g];
    end
  end

  mwb_pick #(.N(DEPTH), .IDX_W(IDX_W)) u_pick (
    .req  (merge_ok),
    .found(can_merge),
    .idx  (m_idx)
  );

  assign pop_valid = (count_q != '0);
  assign pop_fire  = pop_valid && pop_ready;
  assign pop_addr  = ent_base[0];
  assign pop_len   = ent_len[0];
  assign occupancy = count_q;

  always_comb begin
    if (!wr_valid)                        act = WA_NONE;
    else if (can_merge)                   act = WA_MERGE;
    else if (count_q < CNT_W'(DEPTH))     act = WA_ALLOC;
    else                                  act = WA_STALL;
    wr_ready = can_merge || (count_q < CNT_W'(DEPTH));
    wr_acc   = (act == WA_MERGE) || (act == WA_ALLOC);
  end

  mwb_store #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH(DEPTH), .BURST(BURST_BYTES),
    .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .merge_en  (act == WA_MERGE),
    .merge_idx (m_idx),
    .merge_base(join_base[m_idx]),
    .merge_len (join_len[m_idx]),
    .alloc_en  (act == WA_ALLOC),
    .alloc_base(wr_addr),
    .alloc_len (wr_len),
    .pop_en    (pop_fire),
    .base_q    (ent_base),
    .len_q     (ent_len),
    .valid     (ent_valid),
    .count_q   (count_q)
  );

  // read lookup result and acceptance statistic
  always_comb begin
    hit_n  = rd_valid && (|covers);
    acc_en = wr_acc;
    acc_n  = acc_q + STAT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      acc_q <= '0;
    end else begin
      hit_q <= hit_n;
      if (acc_en) acc_q <= acc_n;
    end
  end

  assign rd_hit     = hit_q;
  assign accept_cnt = acc_q;

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !pop_fire) |=> $stable(occupancy));

  // R5
  hit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> $past(rd_valid));

  // R6
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && !(wr_valid && wr_ready)) |=> (occupancy == $past(occupancy) - CNT_W'(1)));

  // R8
  accept_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> $stable(accept_cnt));

endmodule

// File: tb/merging_wbuf_tb_top.sv
`timescale 1ns/1ps
module merging_wbuf_tb_top;
  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_RD  = 2'd1;
  localparam logic [1:0] OP_POP = 2'd2;

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  op;
    logic [15:0] addr;
    logic [6:0]  len;
    logic [15:0] exp_a;
    logic [6:0]  exp_len;
    logic [2:0]  exp_occ;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'd7, OP_WR,  16'h0100, 7'd16, 16'd1,     7'd0,  3'd1}, // R7 first alloc
    '{4'd1, OP_WR,  16'h0108, 7'd16, 16'd1,     7'd0,  3'd1}, // R1 overlap
    '{4'd2, OP_WR,  16'h0118, 7'd8,  16'd1,     7'd0,  3'd1}, // R2 follows
    '{4'd2, OP_WR,  16'h00F0, 7'd16, 16'd1,     7'd0,  3'd1}, // R2 precedes
    '{4'd7, OP_WR,  16'h0200, 7'd8,  16'd1,     7'd0,  3'd2}, // R7 second alloc
    '{4'd2, OP_WR,  16'h0209, 7'd4,  16'd1,     7'd0,  3'd3}, // R2 one-byte gap
    '{4'd5, OP_RD,  16'h0100, 7'd16, 16'd1,     7'd0,  3'd3}, // R5 inside
    '{4'd5, OP_RD,  16'h011C, 7'd8,  16'd0,     7'd0,  3'd3}, // R5 past end
    '{4'd5, OP_RD,  16'h0208, 7'd1,  16'd0,     7'd0,  3'd3}, // R5 in gap
    '{4'd3, OP_WR,  16'h0120, 7'd24, 16'd1,     7'd0,  3'd4}, // R3 too wide
    '{4'd4, OP_WR,  16'h0300, 7'd4,  16'd0,     7'd0,  3'd4}, // R4 full stall
    '{4'd9, OP_WR,  16'h0208, 7'd1,  16'd1,     7'd0,  3'd4}, // R9 lowest slot, R4 merge when full
    '{4'd6, OP_POP, 16'h0000, 7'd0,  16'h00F0,  7'd48, 3'd3}, // R6
    '{4'd6, OP_POP, 16'h0000, 7'd0,  16'h0200,  7'd9,  3'd2}, // R6
    '{4'd6, OP_POP, 16'h0000, 7'd0,  16'h0209,  7'd4,  3'd1}, // R6
    '{4'd6, OP_POP, 16'h0000, 7'd0,  16'h0120,  7'd24, 3'd0}  // R6
  };

  logic        clk, rst_n;
  logic        wr_valid, wr_ready, rd_valid, rd_hit, pop_valid, pop_ready;
  logic [15:0] wr_addr, rd_addr, pop_addr, accept_cnt;
  logic [6:0]  wr_len, rd_len, pop_len;
  logic [2:0]  occupancy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  merging_wbuf dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_len(wr_len),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_len(rd_len), .rd_hit(rd_hit),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_addr(pop_addr), .pop_len(pop_len),
    .occupancy(occupancy), .accept_cnt(accept_cnt)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_valid = 1'b0; rd_valid = 1'b0; pop_ready = 1'b0;
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [6:0] l, input logic pop);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_len = l; pop_ready = pop;
  endtask

  task automatic do_rd(input logic [15:0] a, input logic [6:0] l);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a; rd_len = l;
  endtask

  task automatic finish_cycle();
    @(negedge clk);
    idle_inputs();
    #1;
  endtask

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    wr_addr = '0; wr_len = '0; rd_addr = '0; rd_len = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk("R10 occupancy", occupancy, 0);
    chk("R10 pop_valid", pop_valid, 0);
    chk("R10 rd_hit", rd_hit, 0);
    chk("R10 accept_cnt", accept_cnt, 0);
    chk("R10 wr_ready", wr_ready, 1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = VECS[i];
      tag = $sformatf("R%0d vec%0d", v.req, i);
      @(negedge clk);
      case (v.op)
        OP_WR:  begin wr_valid = 1'b1; wr_addr = v.addr; wr_len = v.len; end
        OP_RD:  begin rd_valid = 1'b1; rd_addr = v.addr; rd_len = v.len; end
        default: pop_ready = 1'b1;
      endcase
      #1;
      if (v.op == OP_WR) chk({tag, " wr_ready"}, wr_ready, v.exp_a[0]);
      if (v.op == OP_POP) begin
        chk({tag, " pop_valid"}, pop_valid, 1);
        chk({tag, " pop_addr"}, pop_addr, v.exp_a);
        chk({tag, " pop_len"}, pop_len, v.exp_len);
      end
      finish_cycle();
      if (v.op == OP_RD) chk({tag, " rd_hit"}, rd_hit, v.exp_a[0]);
      chk({tag, " occupancy"}, occupancy, v.exp_occ);
    end

    // R8: stalled write (vec10) must not be counted
    chk("R8 accept_cnt after table", accept_cnt, 8);
    // R6 empty after draining
    chk("R6 pop_valid empty", pop_valid, 0);

    // R7: pop request on empty buffer changes nothing
    @(negedge clk); pop_ready = 1'b1;
    finish_cycle();
    chk("R7 occupancy empty pop", occupancy, 0);

    // R9: head being popped is not a merge target
    do_wr(16'h0400, 7'd8, 1'b0);
    finish_cycle();
    chk("R9 setup occupancy", occupancy, 1);
    do_wr(16'h0408, 7'd8, 1'b1);
    #1;
    chk("R6 pop_addr before pop", pop_addr, 16'h0400);
    chk("R9 wr_ready", wr_ready, 1);
    finish_cycle();
    chk("R9 occupancy", occupancy, 1);
    chk("R9 new head addr", pop_addr, 16'h0408);
    chk("R9 new head len", pop_len, 8);

    // R5 exact-range read hits, then rd_hit drops without rd_valid
    do_rd(16'h0408, 7'd8);
    finish_cycle();
    chk("R5 exact hit", rd_hit, 1);
    @(negedge clk); #1;
    chk("R5 hit clears", rd_hit, 0);

    // drain and read miss
    @(negedge clk); pop_ready = 1'b1;
    finish_cycle();
    chk("R6 drained", pop_valid, 0);
    do_rd(16'h0408, 7'd8);
    finish_cycle();
    chk("R5 miss on empty", rd_hit, 0);
    chk("R8 accept_cnt final", accept_cnt, 10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule